// File: doc/BRIEF.md
# Single-Wire Battery Gauge Bus Master

This block lets a processor talk to a battery gauge over one open-drain wire. Software reaches it through a small 32-bit register bus, and each register carries one byte of data. Software starts one of three line operations by writing the control register. A break pulse resets the slave. A transmit sends the byte held in the transmit register. A receive collects one byte that the slave clocks out. The block pulls the wire low through an output-enable and samples the wire through a two-stage synchronizer. When an operation ends, the block sets a completion flag and, if enabled, raises an interrupt.

All line timing is set in clock counts through parameters. Bytes travel least significant bit first. On transmit, a 1 is a short low pulse and a 0 is a long low pulse, and each bit slot lasts a fixed number of clocks. On receive, each bit is sampled a fixed delay after the slave pulls the wire low. A soft reset bit clears every register, aborts any line activity and holds the reset-done flag low for a few clocks.

Top module: `sw_gauge_master`

## Requirements
- R1: After reset, these registers read as follows. Control reads 0 and interrupt status reads 0. Once RST_CYCLES clocks have passed, system status bit0 (reset done) reads 1. The revision register reads {REV_MAJOR in bits 7:4, REV_MINOR in bits 3:0}. The line is released and irq is low.
- R2: A control write sets bit4 (GO). It also has bit5 (clock enable) set, bit1 (direction) = 0 and bit2 = 0. This write transmits the transmit-data byte (offset 0x04) least significant bit first. Each bit slot drives the line low for T_LOW1 clocks for a 1 or T_LOW0 clocks for a 0, then releases it until T_CYCLE clocks have passed.
- R3: When a transmit ends, interrupt status bit2 is set and control bit4 (GO) returns to 0 by itself.
- R4: A control write with bit2 (initialization) and GO both set drives the line low for T_BREAK clocks, then releases it for T_RECOVER clocks. It then sets interrupt status bit0 and clears bits 2 and 4 of control.
- R5: GO with direction = 1 receives a byte without driving the line. Each bit is sampled T_SAMPLE clocks after the synchronized falling edge made by the slave, least significant bit first. The byte is stored in receive data (offset 0x08) and interrupt status bit1 is set. Clearing direction afterwards changes neither register.
- R6: A read of interrupt status (offset 0x10) returns its value and clears it. Writes to that register have no effect.
- R7: irq is high exactly while control bit6 (interrupt enable) is 1 and any of interrupt status bits 2:0 is 1.
- R8: A control write arriving while GO reads 1 is ignored entirely, including its direction bit.
- R9: While clock enable is written as 0, GO is not kept and no line operation starts.
- R10: Writing 1 to system config bit1 (offset 0x14) returns every register to its reset value and aborts line activity. It drops reset done (offset 0x18, bit0) to 0 for RST_CYCLES clocks. System config bit0 is a read/write autoidle flag.
- R11: Register byte offsets are 0x00 revision, 0x04 transmit data, 0x08 receive data, 0x0C control, 0x10 interrupt status, 0x14 system config and 0x18 system status. Read data appears on bus_rdata in the cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wdata | input | 32 | Write data (low byte used) |
| bus_rdata | output | 32 | Registered read data |
| line_in | input | 1 | Level sensed on the wire |
| line_oe | output | 1 | 1 pulls the wire low |
| irq | output | 1 | Interrupt request |

## Verification
The hardest state to reach from the ports is a control write that lands while an operation is still running. The stimulus reaches it by issuing a second control write, with a changed direction bit, in the middle of a transmit. It then confirms that the pulse stream, the control readback and the completion flag all match a plain transmit. Receive needs a slave on the wire, so the bench models one. Its low pulses fall on both sides of the sample point, which exercises both bit values.

// File: rtl/sgm_pkg.sv
// Shared offsets, control bit positions and the operation code used by the
// single-wire gauge master. Assumes byte offsets on a 5-bit address.
package sgm_pkg;
    localparam logic [4:0] OFS_REV   = 5'h00;
    localparam logic [4:0] OFS_TXD   = 5'h04;
    localparam logic [4:0] OFS_RXD   = 5'h08;
    localparam logic [4:0] OFS_CTRL  = 5'h0C;
    localparam logic [4:0] OFS_IRQS  = 5'h10;
    localparam logic [4:0] OFS_SCFG  = 5'h14;
    localparam logic [4:0] OFS_SSTAT = 5'h18;

    localparam int CB_MODE  = 0;
    localparam int CB_DIR   = 1;
    localparam int CB_INIT  = 2;
    localparam int CB_GO    = 4;
    localparam int CB_CLKEN = 5;
    localparam int CB_INTEN = 6;

    localparam int SB_BREAK = 0;
    localparam int SB_RECV  = 1;
    localparam int SB_SEND  = 2;

    typedef enum logic [1:0] {OP_NONE, OP_BREAK, OP_SEND, OP_RECV} sgm_op_e;
endpackage

// File: rtl/sgm_sync.sv
// Multi-stage synchronizer for the sensed wire level.
// Assumes the wire idles high; the reset value reflects that.
module sgm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // shift the sampled level through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/sgm_seq.sv
// Line sequencer: break pulse, byte transmit and byte receive on the wire.
// Assumes start arrives only while idle and line_lvl is already synchronized.
// done is a one-cycle pulse in the cycle after the last clock of an operation.
module sgm_seq
    import sgm_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int T_LOW1    = 4,
    parameter int T_LOW0    = 12,
    parameter int T_CYCLE   = 20,
    parameter int T_BREAK   = 40,
    parameter int T_RECOVER = 10,
    parameter int T_SAMPLE  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              abort,
    input  logic              start,
    input  sgm_op_e           op,
    input  logic [DATA_W-1:0] tx_byte,
    input  logic              line_lvl,
    output logic              busy,
    output logic              done,
    output sgm_op_e           done_op,
    output logic [DATA_W-1:0] rx_byte,
    output logic              line_oe
);
    localparam int M1   = (T_CYCLE > T_BREAK) ? T_CYCLE : T_BREAK;
    localparam int M2   = (T_RECOVER > T_SAMPLE) ? T_RECOVER : T_SAMPLE;
    localparam int MAXT = (M1 > M2) ? M1 : M2;
    localparam int CW   = $clog2(MAXT + 1);
    localparam int BW   = (DATA_W > 1) ? $clog2(DATA_W) : 1;

    typedef enum logic [2:0] {
        S_IDLE, S_BRK_LOW, S_BRK_REC, S_TX_SLOT, S_RX_WAIT, S_RX_SAMP, S_RX_REL
    } seq_st_e;

    seq_st_e           state;
    logic [CW-1:0]     cnt;
    logic [BW-1:0]     bitn;
    logic [DATA_W-1:0] shreg;
    logic              lvl_q;
    logic              last_bit;

    assign last_bit = (bitn == BW'(DATA_W - 1));

    // walk the operation state machine and its slot counter
    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            state   <= S_IDLE;
            cnt     <= '0;
            bitn    <= '0;
            shreg   <= '0;
            lvl_q   <= 1'b1;
            done    <= 1'b0;
            done_op <= OP_NONE;
        end else begin
            done  <= 1'b0;
            lvl_q <= line_lvl;
            unique case (state)
                S_IDLE: if (start) begin
                    cnt  <= '0;
                    bitn <= '0;
                    unique case (op)
                        OP_BREAK: state <= S_BRK_LOW;
                        OP_SEND:  begin shreg <= tx_byte; state <= S_TX_SLOT; end
                        OP_RECV:  begin shreg <= '0;      state <= S_RX_WAIT; end
                        default:  state <= S_IDLE;
                    endcase
                end
                S_BRK_LOW: begin
                    if (cnt == CW'(T_BREAK - 1)) begin cnt <= '0; state <= S_BRK_REC; end
                    else cnt <= cnt + 1'b1;
                end
                S_BRK_REC: begin
                    if (cnt == CW'(T_RECOVER - 1)) begin
                        state <= S_IDLE; done <= 1'b1; done_op <= OP_BREAK;
                    end else cnt <= cnt + 1'b1;
                end
                S_TX_SLOT: begin
                    if (cnt == CW'(T_CYCLE - 1)) begin
                        cnt   <= '0;
                        shreg <= shreg >> 1;
                        if (last_bit) begin
                            state <= S_IDLE; done <= 1'b1; done_op <= OP_SEND;
                        end else bitn <= bitn + 1'b1;
                    end else cnt <= cnt + 1'b1;
                end
                S_RX_WAIT: if (lvl_q && !line_lvl) begin
                    cnt   <= '0;
                    state <= S_RX_SAMP;
                end
                S_RX_SAMP: begin
                    if (cnt == CW'(T_SAMPLE - 1)) begin
                        shreg <= {line_lvl, shreg[DATA_W-1:1]};
                        state <= S_RX_REL;
                    end else cnt <= cnt + 1'b1;
                end
                S_RX_REL: if (line_lvl) begin
                    if (last_bit) begin
                        state <= S_IDLE; done <= 1'b1; done_op <= OP_RECV;
                    end else begin
                        bitn  <= bitn + 1'b1;
                        state <= S_RX_WAIT;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // pull the wire low during a break or the low part of a transmit slot
    always_comb begin
        unique case (state)
            S_BRK_LOW: line_oe = 1'b1;
            S_TX_SLOT: line_oe = (cnt < (shreg[0] ? CW'(T_LOW1) : CW'(T_LOW0)));
            default:   line_oe = 1'b0;
        endcase
    end

    assign busy    = (state != S_IDLE);
    assign rx_byte = shreg;
endmodule

// File: rtl/sgm_regs.sv
// Register file: control with self-clearing GO/INIT, read-to-clear status,
// soft reset with a reset-done countdown, and registered read data.
// Assumes single-cycle read and write strobes that never overlap.
module sgm_regs
    import sgm_pkg::*;
#(
    parameter int         DATA_W     = 8,
    parameter int         RST_CYCLES = 4,
    parameter logic [3:0] REV_MAJOR  = 4'h2,
    parameter logic [3:0] REV_MINOR  = 4'h1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [4:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              seq_done,
    input  sgm_op_e           seq_done_op,
    input  logic [DATA_W-1:0] seq_rx_byte,
    output logic              start,
    output sgm_op_e           start_op,
    output logic [DATA_W-1:0] tx_byte,
    output logic              soft_pulse,
    output logic              go_bit,
    output logic [2:0]        irq_stat,
    output logic              reset_done,
    output logic              irq
);
    localparam int RCW = $clog2(RST_CYCLES + 1);

    logic              mode_q, dir_q, init_q, clken_q, inten_q, autoidle_q;
    logic [DATA_W-1:0] rxd_q;
    logic [RCW-1:0]    rst_cnt;
    logic              wr_ctrl;
    logic [2:0]        set_bits;

    assign wr_ctrl    = bus_wr && (bus_addr == OFS_CTRL);
    assign soft_pulse = bus_wr && (bus_addr == OFS_SCFG) && bus_wdata[1];
    assign start      = wr_ctrl && !go_bit && bus_wdata[CB_GO] && bus_wdata[CB_CLKEN];
    assign start_op   = bus_wdata[CB_INIT] ? OP_BREAK :
                        (bus_wdata[CB_DIR] ? OP_RECV : OP_SEND);

    // map the finished operation to its completion flag
    always_comb begin
        set_bits = 3'b000;
        if (seq_done) begin
            unique case (seq_done_op)
                OP_BREAK: set_bits[SB_BREAK] = 1'b1;
                OP_RECV:  set_bits[SB_RECV]  = 1'b1;
                OP_SEND:  set_bits[SB_SEND]  = 1'b1;
                default:  set_bits = 3'b000;
            endcase
        end
    end

    // hold control, data, status and configuration state
    always_ff @(posedge clk) begin
        if (!rst_n || soft_pulse) begin
            {mode_q, dir_q, init_q, go_bit, clken_q, inten_q} <= '0;
            autoidle_q <= 1'b0;
            tx_byte    <= '0;
            rxd_q      <= '0;
            irq_stat   <= '0;
            rst_cnt    <= RCW'(RST_CYCLES);
        end else begin
            if (rst_cnt != '0) rst_cnt <= rst_cnt - 1'b1;
            if (bus_wr && bus_addr == OFS_TXD)  tx_byte    <= bus_wdata[DATA_W-1:0];
            if (bus_wr && bus_addr == OFS_SCFG) autoidle_q <= bus_wdata[0];
            if (wr_ctrl && !go_bit) begin
                mode_q  <= bus_wdata[CB_MODE];
                dir_q   <= bus_wdata[CB_DIR];
                init_q  <= bus_wdata[CB_INIT];
                clken_q <= bus_wdata[CB_CLKEN];
                inten_q <= bus_wdata[CB_INTEN];
                go_bit  <= start;
            end
            if (seq_done) begin
                go_bit <= 1'b0;
                init_q <= 1'b0;
            end
            if (seq_done && seq_done_op == OP_RECV) rxd_q <= seq_rx_byte;
            irq_stat <= ((bus_rd && bus_addr == OFS_IRQS) ? 3'b000 : irq_stat) | set_bits;
        end
    end

    // capture read data one cycle after the strobe
    always_ff @(posedge clk) begin
        if (!rst_n) bus_rdata <= '0;
        else if (bus_rd) begin
            unique case (bus_addr)
                OFS_REV:   bus_rdata <= {24'b0, REV_MAJOR, REV_MINOR};
                OFS_TXD:   bus_rdata <= 32'(tx_byte);
                OFS_RXD:   bus_rdata <= 32'(rxd_q);
                OFS_CTRL:  bus_rdata <= {25'b0, inten_q, clken_q, go_bit, 1'b0, init_q, dir_q, mode_q};
                OFS_IRQS:  bus_rdata <= {29'b0, irq_stat};
                OFS_SCFG:  bus_rdata <= {31'b0, autoidle_q};
                OFS_SSTAT: bus_rdata <= {31'b0, reset_done};
                default:   bus_rdata <= '0;
            endcase
        end
    end

    assign reset_done = (rst_cnt == '0);
    assign irq        = inten_q && (irq_stat != 3'b000);
endmodule

// File: rtl/sw_gauge_master.sv
// Top of the single-wire gauge bus master: register file, line synchronizer
// and line sequencer. Assumes an external pull-up keeps the wire high when
// line_oe is 0.
module sw_gauge_master
    import sgm_pkg::*;
#(
    parameter int         DATA_W     = 8,
    parameter int         SYNC_STG   = 2,
    parameter int         RST_CYCLES = 4,
    parameter logic [3:0] REV_MAJOR  = 4'h2,
    parameter logic [3:0] REV_MINOR  = 4'h1,
    parameter int         T_LOW1     = 4,
    parameter int         T_LOW0     = 12,
    parameter int         T_CYCLE    = 20,
    parameter int         T_BREAK    = 40,
    parameter int         T_RECOVER  = 10,
    parameter int         T_SAMPLE   = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [4:0]  bus_addr,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        line_in,
    output logic        line_oe,
    output logic        irq
);
    logic              line_lvl, start, soft_pulse, go_bit, reset_done;
    logic              seq_busy, seq_done;
    sgm_op_e           start_op, seq_done_op;
    logic [DATA_W-1:0] tx_byte, seq_rx_byte;
    logic [2:0]        irq_stat;

    sgm_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(line_in), .q(line_lvl)
    );

    sgm_regs #(
        .DATA_W(DATA_W), .RST_CYCLES(RST_CYCLES),
        .REV_MAJOR(REV_MAJOR), .REV_MINOR(REV_MINOR)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .seq_done(seq_done), .seq_done_op(seq_done_op), .seq_rx_byte(seq_rx_byte),
        .start(start), .start_op(start_op), .tx_byte(tx_byte),
        .soft_pulse(soft_pulse), .go_bit(go_bit), .irq_stat(irq_stat),
        .reset_done(reset_done), .irq(irq)
    );

    sgm_seq #(
        .DATA_W(DATA_W), .T_LOW1(T_LOW1), .T_LOW0(T_LOW0), .T_CYCLE(T_CYCLE),
        .T_BREAK(T_BREAK), .T_RECOVER(T_RECOVER), .T_SAMPLE(T_SAMPLE)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .abort(soft_pulse), .start(start),
        .op(start_op), .tx_byte(tx_byte), .line_lvl(line_lvl),
        .busy(seq_busy), .done(seq_done), .done_op(seq_done_op),
        .rx_byte(seq_rx_byte), .line_oe(line_oe)
    );
endmodule

// File: rtl/sgm_chk.sv
// Temporal checks on the gauge master, attached to the top by bind.
// Assumes the signal names of sw_gauge_master.
module sgm_chk
    import sgm_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic [4:0] bus_addr,
    input logic       bus_rd,
    input logic       line_oe,
    input logic       go_bit,
    input logic       seq_busy,
    input logic       seq_done,
    input logic       soft_pulse,
    input logic       reset_done,
    input logic [2:0] irq_stat
);
    // R2
    oe_needs_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_oe |-> go_bit);

    // R8
    busy_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_busy |-> go_bit);

    // R3
    go_selfclear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_done && !soft_pulse) |=> !go_bit);

    // R6
    stat_rdclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == OFS_IRQS && !seq_done) |=> (irq_stat == 3'b000));

    // R5
    stat_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(irq_stat) > $countones($past(irq_stat))) |-> $past(seq_done));

    // R10
    soft_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_pulse |=> (!reset_done && !go_bit && irq_stat == 3'b000));
endmodule

bind sw_gauge_master sgm_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .line_oe(line_oe), .go_bit(go_bit), .seq_busy(seq_busy),
    .seq_done(seq_done), .soft_pulse(soft_pulse), .reset_done(reset_done),
    .irq_stat(irq_stat)
);

// File: tb/sw_gauge_master_bench.sv
// Scoreboard bench: the driver queues expected low-pulse widths, and a
// monitor measures each pulse on line_oe and compares it.
module sw_gauge_master_bench;
    localparam int CLK_PERIOD = 10;
    localparam int T_LOW1 = 4, T_LOW0 = 12, T_CYCLE = 20;
    localparam int T_BREAK = 40, T_RECOVER = 10, T_SAMPLE = 8;
    localparam int RST_CYCLES = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        line_oe, irq, line_in;
    logic        slave_low = 1'b0;
    int          n_chk = 0, n_fail = 0;
    int          expq[$];
    logic [31:0] rv;

    assign line_in = !(line_oe || slave_low);

    always #(CLK_PERIOD/2) clk = ~clk;

    sw_gauge_master #(
        .RST_CYCLES(RST_CYCLES), .REV_MAJOR(4'h2), .REV_MINOR(4'h1),
        .T_LOW1(T_LOW1), .T_LOW0(T_LOW0), .T_CYCLE(T_CYCLE),
        .T_BREAK(T_BREAK), .T_RECOVER(T_RECOVER), .T_SAMPLE(T_SAMPLE)
    ) u_sw_gauge_master (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .line_in(line_in), .line_oe(line_oe), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk); bus_addr = a; bus_rd = 1'b1;
        @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
    endtask

    task automatic push_byte(input logic [7:0] b);
        for (int i = 0; i < 8; i++) expq.push_back(b[i] ? T_LOW1 : T_LOW0);
    endtask

    task automatic wait_irq(input string req);
        int k = 0;
        while (!irq && k < 3000) begin @(negedge clk); k++; end
        check({req, " irq seen"}, {31'b0, irq}, 32'd1);
    endtask

    task automatic slave_send(input logic [7:0] b);
        for (int i = 0; i < 8; i++) begin
            repeat (3) @(negedge clk);
            slave_low = 1'b1;
            repeat (b[i] ? 4 : 14) @(negedge clk);
            slave_low = 1'b0;
            repeat (6) @(negedge clk);
        end
    endtask

    // monitor: measure each low pulse and compare with the queued width (R2, R4)
    initial begin
        int run = 0;
        forever begin
            @(negedge clk);
            if (line_oe) run++;
            else if (run > 0) begin
                if (expq.size() == 0) check("R2/R9 unexpected pulse", run, 0);
                else check("R2/R4 pulse width", run, expq.pop_front());
                run = 0;
            end
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(negedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=expired expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (RST_CYCLES + 4) @(negedge clk);
        // R1 reset state, R11 offsets
        rd(5'h0C, rv); check("R1 ctrl", rv, 32'h0);
        rd(5'h10, rv); check("R1 status", rv, 32'h0);
        rd(5'h18, rv); check("R1 reset done", rv, 32'h1);
        rd(5'h00, rv); check("R1 R11 revision", rv, 32'h21);
        check("R1 line", {31'b0, line_oe}, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);

        // R4 break
        wr(5'h0C, 32'h60);
        expq.push_back(T_BREAK);
        wr(5'h0C, 32'h74);
        rd(5'h0C, rv); check("R4 go set while busy", rv, 32'h74);
        wait_irq("R4");
        rd(5'h10, rv); check("R4 timeout flag", rv, 32'h1);
        rd(5'h0C, rv); check("R4 init and go cleared", rv, 32'h60);
        check("R6 R7 irq after read", {31'b0, irq}, 32'h0);

        // R2 R3 transmit, with R8 ignored write mid-transfer
        wr(5'h04, 32'hA5);
        push_byte(8'hA5);
        wr(5'h0C, 32'h70);
        repeat (30) @(negedge clk);
        wr(5'h0C, 32'h72);
        rd(5'h0C, rv); check("R8 write while busy ignored", rv, 32'h70);
        wait_irq("R3");
        rd(5'h10, rv); check("R3 R8 tx complete only", rv, 32'h4);
        rd(5'h0C, rv); check("R3 go cleared", rv, 32'h60);

        wr(5'h04, 32'h3C);
        push_byte(8'h3C);
        wr(5'h0C, 32'h70);
        wait_irq("R2");
        rd(5'h10, rv); check("R2 second tx complete", rv, 32'h4);

        // R5 receive
        wr(5'h0C, 32'h72);
        slave_send(8'h96);
        wait_irq("R5");
        rd(5'h10, rv); check("R5 rx complete", rv, 32'h2);
        rd(5'h08, rv); check("R5 rx data", rv, 32'h96);
        wr(5'h0C, 32'h60);
        rd(5'h10, rv); check("R5 dir clear no status", rv, 32'h0);
        rd(5'h08, rv); check("R5 dir clear keeps data", rv, 32'h96);
        wr(5'h0C, 32'h72);
        slave_send(8'h01);
        wait_irq("R5");
        rd(5'h08, rv); check("R5 rx data 2", rv, 32'h01);
        rd(5'h10, rv); check("R5 rx complete 2", rv, 32'h2);

        // R7 interrupt disabled: flag set, irq stays low
        wr(5'h04, 32'hFF);
        push_byte(8'hFF);
        wr(5'h0C, 32'h30);
        repeat (8*T_CYCLE + 20) @(negedge clk);
        check("R7 irq masked", {31'b0, irq}, 32'h0);
        rd(5'h10, rv); check("R7 flag still set", rv, 32'h4);

        // R6 writes to status ignored
        wr(5'h0C, 32'h60);
        wr(5'h10, 32'h7);
        check("R6 R7 irq after status write", {31'b0, irq}, 32'h0);
        rd(5'h10, rv); check("R6 status write ignored", rv, 32'h0);

        // R9 no start without clock enable
        wr(5'h0C, 32'h50);
        repeat (100) @(negedge clk);
        rd(5'h0C, rv); check("R9 go not kept", rv, 32'h40);
        rd(5'h10, rv); check("R9 no completion", rv, 32'h0);

        // R10 autoidle and soft reset
        wr(5'h14, 32'h1);
        rd(5'h14, rv); check("R10 autoidle rw", rv, 32'h1);
        wr(5'h0C, 32'h60);
        wr(5'h14, 32'h2);
        rd(5'h18, rv); check("R10 reset done low", rv, 32'h0);
        repeat (RST_CYCLES + 4) @(negedge clk);
        rd(5'h18, rv); check("R10 reset done high", rv, 32'h1);
        rd(5'h14, rv); check("R10 sysconfig cleared", rv, 32'h0);
        rd(5'h0C, rv); check("R10 ctrl cleared", rv, 32'h0);

        repeat (5) @(negedge clk);
        check("R2 all pulses seen", expq.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule